// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial memory. It oversamples the clock and data lines with the system clock, finds start and stop conditions, shifts bytes in and out, and acknowledges by pulling the data line low. The memory is an internal byte array organised in pages. A master reaches it the usual way: a select byte carrying a fixed code, three strap bits and a direction bit, then a two-byte word address and data for a write, or a read that starts from the internal address pointer.

Writes are collected in a page buffer and reach the array only when the master ends the write with a stop. The array then goes busy for a set number of system clocks, and select bytes are not acknowledged during that time, so a master can poll for the end of the write. A write-protect input leaves the array untouched while the protocol runs to completion. The data output is an open-drain pull-low enable.

Top module: `twi_mem_slave`

## Requirements
- R1: A start (data falls while the clock is high) abandons any transfer in progress. A stop (data rises while the clock is high) that arrives after two to seven data bits of a byte discards the buffered write.
- R2: A select byte is acknowledged only when bits 7..4 are 1010, bits 3..1 equal `strap_i[2:0]`, and no write is in progress. Bit 0 is the direction: 1 for read, 0 for write. An unmatched select byte is not acknowledged, and the slave stays silent until the next start.
- R3: Every accepted byte is acknowledged by pulling data low for the whole ninth clock. `sda_pull_o` changes only while the clock is low.
- R4: After a write select byte, the next two bytes form the word address with the high byte first. Only the low `ADDR_W` bits select an array location.
- R5: Buffered write data reaches the array only on a stop at a byte boundary after at least one complete data byte. A repeated start, or a stop that comes before any data byte, commits nothing and starts no busy period.
- R6: A commit starts a busy period of `BUSY_CYC` system clocks. During it, select bytes get no acknowledge. After it, they are acknowledged again.
- R7: In a write, the low `PAGE_W` address bits advance after each data byte and wrap inside the page. Bytes past the page size overwrite earlier bytes of the same write, and other pages are left unchanged.
- R8: While `wp_i` is high at the stop, all bytes are still acknowledged, but the array does not change and no busy period starts.
- R9: Read data is shifted out MSB first. A master acknowledge brings the next byte. The pointer runs across page ends and wraps from the last array location to location 0.
- R10: A write header that carries only the word address, followed by a repeated start and a read select byte, returns the data at that address.
- R11: A read that starts without an address begins at the location after the last byte that was read or written.
- R12: Reset releases the data line and clears the array to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_pull_o | output | 1 | Pull the data line low when 1 |
| strap_i | input | 3 | Device strap bits compared in the select byte |
| wp_i | input | 1 | Write protect; high blocks all array writes |

## Verification
The hardest situations to reach from the ports are the ones where the protocol stops at an unusual point. These are a stop after only three bits of a data byte, a repeated start straight after a data byte, and a select byte sent while a commit is still busy. The stimulus model drives the bus at bit level, so it can cut a byte short, leave out the stop, or poll a few bus clocks after a stop. Every outcome is then read back through a normal random read, or seen in whether the select byte was acknowledged.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RX      = 3'd1,
        ST_ACKWAIT = 3'd2,
        ST_ACK     = 3'd3,
        ST_TX      = 3'd4,
        ST_MACK    = 3'd5,
        ST_TXWAIT  = 3'd6
    } fsm_e;

    // meaning of the byte currently being received
    typedef enum logic [1:0] {
        RL_SEL = 2'd0,
        RL_AHI = 2'd1,
        RL_ALO = 2'd2,
        RL_DAT = 2'd3
    } role_e;

    localparam logic [3:0] SEL_CODE = 4'b1010;

endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_p;
        logic [SYNC_STAGES-1:0] sda_p;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_p    = {smp_q.scl_p[SYNC_STAGES-2:0], scl_i};
        smp_d.sda_p    = {smp_q.sda_p[SYNC_STAGES-2:0], sda_i};
        smp_d.scl_prev = smp_q.scl_p[SYNC_STAGES-1];
        smp_d.sda_prev = smp_q.sda_p[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_hi   = smp_q.scl_p[SYNC_STAGES-1];
    assign sda_hi   = smp_q.sda_p[SYNC_STAGES-1];
    assign scl_rise = scl_hi & ~smp_q.scl_prev;
    assign scl_fall = ~scl_hi & smp_q.scl_prev;
    assign start_ev = scl_hi & smp_q.scl_prev & smp_q.sda_prev & ~sda_hi;
    assign stop_ev  = scl_hi & smp_q.scl_prev & ~smp_q.sda_prev & sda_hi;

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [7:0]                   rd_data,
    input  logic                         wr_en,
    input  logic [ADDR_W-PAGE_W-1:0]     wr_row,
    input  logic [(1<<PAGE_W)*8-1:0]     wr_bytes,
    input  logic [(1<<PAGE_W)-1:0]       wr_mask
);

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int ROW_W      = ADDR_W - PAGE_W;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ROW_W-1:0] CROW = ROW_W'(g >> PAGE_W);
        localparam int               CCOL = g % PAGE_BYTES;

        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en && wr_row == CROW && wr_mask[CCOL])
                mem_d[g] = wr_bytes[CCOL*8 +: 8];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int BUSY_CYC    = 500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int BUSY_W     = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        fsm_e                    st;
        role_e                   role;
        logic [2:0]              cnt;
        logic [7:0]              sh;
        logic                    pull;
        logic [7:0]              hi;
        logic [ADDR_W-1:0]       ptr;
        logic [PAGE_BYTES-1:0]   mask;
        logic [PAGE_BYTES*8-1:0] pbuf;
        logic [BUSY_W-1:0]       busy;
    } core_t;

    core_t d, q;

    logic scl_hi, sda_hi, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0]        rd_data;
    logic [7:0]        byte_in;
    logic [PAGE_W-1:0] col;
    logic              commit;

    twi_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_hi   (scl_hi),
        .sda_hi   (sda_hi),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    twi_mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (q.ptr),
        .rd_data  (rd_data),
        .wr_en    (commit),
        .wr_row   (q.ptr[ADDR_W-1:PAGE_W]),
        .wr_bytes (q.pbuf),
        .wr_mask  (q.mask)
    );

    assign byte_in = {q.sh[6:0], sda_hi};
    assign col     = q.ptr[PAGE_W-1:0];

    always_comb begin
        d      = q;
        commit = 1'b0;
        if (q.busy != '0) d.busy = q.busy - 1'b1;

        if (start_ev) begin
            d.st   = ST_RX;
            d.role = RL_SEL;
            d.cnt  = '0;
            d.pull = 1'b0;
            d.mask = '0;
        end else if (stop_ev) begin
            // boundary: at most one bit of the next byte was clocked
            if (q.st == ST_RX && q.role == RL_DAT && q.cnt[2:1] == 2'b00 &&
                q.mask != '0 && !wp_i) begin
                commit = 1'b1;
                d.busy = BUSY_W'(BUSY_CYC);
            end
            d.st   = ST_IDLE;
            d.pull = 1'b0;
            d.mask = '0;
        end else begin
            case (q.st)
                ST_RX: if (scl_rise) begin
                    d.sh  = byte_in;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == 3'd7) begin
                        if (q.role != RL_SEL ||
                            (byte_in[7:4] == SEL_CODE && byte_in[3:1] == strap_i &&
                             q.busy == '0))
                            d.st = ST_ACKWAIT;
                        else
                            d.st = ST_IDLE;
                    end
                end
                ST_ACKWAIT: if (scl_fall) begin
                    d.pull = 1'b1;
                    d.st   = ST_ACK;
                end
                ST_ACK: if (scl_fall) begin
                    d.pull = 1'b0;
                    d.st   = ST_RX;
                    d.cnt  = '0;
                    case (q.role)
                        RL_SEL: begin
                            if (q.sh[0]) begin
                                d.sh   = rd_data;
                                d.ptr  = q.ptr + 1'b1;
                                d.pull = ~rd_data[7];
                                d.st   = ST_TX;
                            end else begin
                                d.role = RL_AHI;
                            end
                        end
                        RL_AHI: begin
                            d.hi   = q.sh;
                            d.role = RL_ALO;
                        end
                        RL_ALO: begin
                            d.ptr  = ADDR_W'({q.hi, q.sh});
                            d.mask = '0;
                            d.role = RL_DAT;
                        end
                        default: begin
                            d.pbuf[{col, 3'b000} +: 8] = q.sh;
                            d.mask[col] = 1'b1;
                            d.ptr = {q.ptr[ADDR_W-1:PAGE_W], col + 1'b1};
                        end
                    endcase
                end
                ST_TX: if (scl_fall) begin
                    if (q.cnt == 3'd7) begin
                        d.pull = 1'b0;
                        d.st   = ST_MACK;
                    end else begin
                        d.sh   = {q.sh[6:0], 1'b0};
                        d.pull = ~q.sh[6];
                        d.cnt  = q.cnt + 1'b1;
                    end
                end
                ST_MACK: if (scl_rise) begin
                    d.st = sda_hi ? ST_IDLE : ST_TXWAIT;
                end
                ST_TXWAIT: if (scl_fall) begin
                    d.sh   = rd_data;
                    d.ptr  = q.ptr + 1'b1;
                    d.pull = ~rd_data[7];
                    d.cnt  = '0;
                    d.st   = ST_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_pull_o = q.pull;

    // R3
    pull_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.pull) |-> !$past(scl_hi));

    // R2
    sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK && q.role == RL_SEL) |->
        (q.sh[7:4] == SEL_CODE && q.sh[3:1] == strap_i));

    // R6
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy != '0) |-> !(q.st == ST_ACK && q.role == RL_SEL));

    // R6
    busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy != '0) |=> (q.busy == $past(q.busy) - 1'b1));

    // R8
    wp_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy != '0 && $past(q.busy) == '0) |-> !$past(wp_i));

    // R5
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy != '0 && $past(q.busy) == '0) |-> $past(stop_ev));

endmodule

// File: tb/twi_mem_slave_test.sv
module twi_mem_slave_test;

    localparam int BUSY = 400;
    localparam int Q    = 10;
    localparam logic [7:0] DEV_W = 8'hAA;   // 1010 strap=101 write
    localparam logic [7:0] DEV_R = 8'hAB;   // 1010 strap=101 read

    // {word address, data}
    localparam logic [23:0] VEC [0:5] = '{
        24'h0000_5A, 24'h00FF_C3, 24'h1234_7E,
        24'h0041_81, 24'h0090_3C, 24'hFF10_E7
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    logic sda_pull;
    logic sda_line;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic [7:0] pdata [16];
    logic [7:0] rdata [16];

    always #5 clk = ~clk;

    assign sda_line = ~(m_low | sda_pull);

    twi_mem_slave #(.ADDR_W(8), .PAGE_W(3), .BUSY_CYC(BUSY), .SYNC_STAGES(2)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .strap_i    (3'b101),
        .wp_i       (wp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; tick(Q);
            m_scl = 1'b1;  tick(Q);
            m_scl = 1'b0;  tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q / 2);
        ack = ~sda_line;
        tick(Q / 2);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q / 2);
            b[i] = sda_line;
            tick(Q / 2);
            m_scl = 1'b0;
        end
        m_low = mack; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(2);
        m_low = 1'b0; tick(Q);
    endtask

    // R3 R4: header and data bytes, each ack checked
    task automatic wr(input logic [15:0] a, input int n, input bit stop_it);
        logic ak;
        bus_start();
        send_byte(DEV_W, ak);  chk(ak, "R3 select ack", ak, 1);
        send_byte(a[15:8], ak); chk(ak, "R4 addr hi ack", ak, 1);
        send_byte(a[7:0], ak);  chk(ak, "R4 addr lo ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(pdata[k], ak);
            chk(ak, "R3 data ack", ak, 1);
        end
        if (stop_it) bus_stop();
    endtask

    task automatic rd_body(input int n);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rdata[k]);
        bus_stop();
    endtask

    task automatic rd_rand(input logic [15:0] a, input int n);
        logic ak;
        bus_start();
        send_byte(DEV_W, ak);
        send_byte(a[15:8], ak);
        send_byte(a[7:0], ak);
        bus_start();
        send_byte(DEV_R, ak);
        chk(ak, "R10 read select ack", ak, 1);
        rd_body(n);
    endtask

    task automatic rd_cur(input int n);
        logic ak;
        bus_start();
        send_byte(DEV_R, ak);
        chk(ak, "R11 read select ack", ak, 1);
        rd_body(n);
    endtask

    task automatic poll(output logic ak);
        bus_start();
        send_byte(DEV_W, ak);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] b;
        tick(3);
        // R12 data line released during reset
        chk(sda_pull == 1'b0, "R12 reset release", sda_pull, 0);
        rst_n = 1'b1;
        tick(20);
        chk(sda_pull == 1'b0, "R12 idle release", sda_pull, 0);

        // R12 array cleared
        rd_rand(16'h0077, 1);
        chk(rdata[0] == 8'h00, "R12 array cleared", rdata[0], 0);

        // vector table: byte write, busy wait, random read back
        for (int v = 0; v < 6; v++) begin
            pdata[0] = VEC[v][7:0];
            wr(VEC[v][23:8], 1, 1'b1);
            if (v == 0) begin
                poll(ak);
                chk(ak == 1'b0, "R6 busy nack", ak, 0);
            end
            tick(BUSY + 100);
            if (v == 0) begin
                poll(ak);
                chk(ak == 1'b1, "R6 ack after busy", ak, 1);
            end
            rd_rand(VEC[v][23:8], 1);
            chk(rdata[0] == VEC[v][7:0], "R10 random read", rdata[0], VEC[v][7:0]);
        end

        // R4 upper address bits do not select a location
        rd_rand(16'h0034, 1);
        chk(rdata[0] == 8'h7E, "R4 high bits ignored", rdata[0], 8'h7E);

        // R9 sequential read wraps from last location to 0
        rd_rand(16'h00FF, 2);
        chk(rdata[0] == 8'hC3, "R9 seq first", rdata[0], 8'hC3);
        chk(rdata[1] == 8'h5A, "R9 seq wrap", rdata[1], 8'h5A);

        // R11 current address read continues after last read
        rd_rand(16'h0040, 1);
        chk(rdata[0] == 8'h00, "R11 prior byte", rdata[0], 0);
        rd_cur(1);
        chk(rdata[0] == 8'h81, "R11 current read", rdata[0], 8'h81);

        // R7 page write of 10 bytes starting at 0x25 wraps in page 0x20..0x27
        for (int k = 0; k < 10; k++) pdata[k] = 8'hA0 + 8'(k);
        wr(16'h0025, 10, 1'b1);
        tick(BUSY + 100);
        rd_rand(16'h0020, 9);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] e;
            e = (k == 7) ? 8'hA2 : 8'hA3 + 8'(k);
            chk(rdata[k] == e, "R7 page wrap", rdata[k], e);
        end
        chk(rdata[8] == 8'h00, "R7 next page untouched", rdata[8], 0);

        // R5 repeated start after a data byte discards the write
        pdata[0] = 8'h11;
        wr(16'h0050, 1, 1'b0);
        bus_start();
        send_byte(DEV_R, ak);
        chk(ak == 1'b1, "R5 read after repeated start", ak, 1);
        recv_byte(1'b0, b);
        bus_stop();
        chk(b == 8'h00, "R5 pointer after data", b, 0);
        poll(ak);
        chk(ak == 1'b1, "R5 no busy after discard", ak, 1);
        rd_rand(16'h0050, 1);
        chk(rdata[0] == 8'h00, "R5 discarded data", rdata[0], 0);

        // R5 stop after the address only
        wr(16'h0060, 0, 1'b1);
        poll(ak);
        chk(ak == 1'b1, "R5 address-only stop", ak, 1);

        // R1 stop in the middle of a byte abandons the write
        pdata[0] = 8'h44;
        wr(16'h0070, 1, 1'b0);
        send_bits(8'h99, 3);
        bus_stop();
        poll(ak);
        chk(ak == 1'b1, "R1 mid-byte stop no busy", ak, 1);
        rd_rand(16'h0070, 1);
        chk(rdata[0] == 8'h00, "R1 mid-byte stop no write", rdata[0], 0);

        // R8 write protect
        wp = 1'b1;
        pdata[0] = 8'hFF;
        wr(16'h0000, 1, 1'b1);
        poll(ak);
        chk(ak == 1'b1, "R8 no busy when protected", ak, 1);
        wp = 1'b0;
        rd_rand(16'h0000, 1);
        chk(rdata[0] == 8'h5A, "R8 array unchanged", rdata[0], 8'h5A);

        // R2 wrong strap not acked, slave silent until next start
        bus_start();
        send_byte(8'hA0, ak);
        chk(ak == 1'b0, "R2 wrong strap nack", ak, 0);
        send_byte(8'h00, ak);
        chk(ak == 1'b0, "R2 silent after mismatch", ak, 0);
        bus_stop();
        bus_start();
        send_byte(8'h2A, ak);
        chk(ak == 1'b0, "R2 wrong code nack", ak, 0);
        bus_stop();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule